// File: doc/BRIEF.md
# Memory Region Scoreboard for a Memory-to-Memory Coprocessor

This block lets a processor keep running while a reconfigurable coprocessor works through block-copy style operations, and it keeps the result as if every access had run in program order. Each coprocessor operation reads one memory block and writes another. Every block is a power of two in size and is given by a base address and a size exponent. When an operation is issued, the scoreboard records both of its regions in a free entry. Each operation stays outstanding until the coprocessor reports that it has finished, giving the entry index.

Every processor load or store is compared against all outstanding regions at the same time. A load stalls if it falls inside a block that a pending operation has yet to write. A store stalls if it falls inside any pending block, whether that block is a source or a destination. A new operation is also held back if its source block overlaps the destination of an earlier operation that is still pending. It is held back as well when every entry is in use.

Top module: `memreg_scoreboard`

## Requirements
- R1: After reset no entry is pending. `acc_stall` is low for every access, and `issue_ready` is high with `issue_idx` = 0.
- R2: A read access (`acc_valid`=1, `acc_write`=0) stalls whenever its address lies inside the destination block of any pending entry.
- R3: A read access whose address lies only inside pending source blocks, or outside every pending block, does not stall.
- R4: A write access (`acc_write`=1) stalls whenever its address lies inside the source block or the destination block of any pending entry. Otherwise it does not stall.
- R5: A block with base B and size exponent L covers the addresses A for which (A xor B) >> L is zero. The low L bits of B are ignored, and the block spans 2^L addresses.
- R6: An accepted issue (`issue_valid` and `issue_ready` both high at a clock edge) takes the lowest-numbered free entry. That index is shown on `issue_idx` in the same cycle, and the entry is pending from the next cycle.
- R7: When all ENTRIES entries are pending, `issue_ready` is low and nothing is recorded.
- R8: `issue_ready` is low while the new source block overlaps the destination block of any pending entry. Two blocks overlap when they agree above the larger of their two size exponents. The issue is accepted in the cycle after that entry is released.
- R9: `done_valid` with index K frees entry K at that clock edge. From the next cycle, K no longer causes stalls and can be allocated again.
- R10: `done_valid` naming an entry that is already free changes nothing.
- R11: With `acc_valid` low, `acc_stall` is low whatever the pending regions are.
- R12: In a cycle where an entry is being freed, the issue decision still sees that entry as pending. With a full table, a same-cycle issue is therefore refused and is accepted in the next cycle with the freed index.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| issue_valid | input | 1 | New coprocessor operation offered |
| issue_src | input | ADDR_W | Source block base |
| issue_dst | input | ADDR_W | Destination block base |
| issue_lg | input | LG_W | Block size exponent (size = 2^issue_lg) |
| issue_ready | output | 1 | Operation can be recorded this cycle |
| issue_idx | output | IDX_W | Entry that an accepted operation takes |
| done_valid | input | 1 | Coprocessor finished an operation |
| done_idx | input | IDX_W | Entry of the finished operation |
| acc_valid | input | 1 | Processor memory access present |
| acc_write | input | 1 | 1 = store, 0 = load |
| acc_addr | input | ADDR_W | Access address |
| acc_stall | output | 1 | Access must wait |

## Verification
The bench sweeps every address of an 8-bit space as both a load and a store against several sets of pending regions. These include unaligned bases and mixed block sizes. A design that mixed up source and destination would stall loads in source blocks. A design that miscomputed the block mask would get the last address of a block, or the one just past it, wrong. A source that touches a pending destination only through the larger of two block sizes is offered, to catch overlap tests that use one operand's size. Freeing and issuing in the same cycle at full occupancy would show a design that reuses an entry too early as a double allocation. A done on an already free entry would show a design that disturbs its neighbours.

// File: rtl/msb_pkg.sv
// Package: shared block-address helpers for the memory region scoreboard.
// Assumes addresses no wider than 64 bits and size exponents below 128.
package msb_pkg;

    localparam int MSB_AW_MAX = 64;

    // True when address a lies inside the 2^lg block that contains base.
    function automatic logic blk_hit(input logic [MSB_AW_MAX-1:0] a,
                                     input logic [MSB_AW_MAX-1:0] base,
                                     input logic [6:0]            lg);
        logic [MSB_AW_MAX-1:0] diff;
        diff = (a ^ base) >> lg;
        return diff == '0;
    endfunction

    // True when two aligned power-of-two blocks share any address.
    function automatic logic blk_overlap(input logic [MSB_AW_MAX-1:0] a,
                                         input logic [6:0]            lga,
                                         input logic [MSB_AW_MAX-1:0] b,
                                         input logic [6:0]            lgb);
        logic [6:0] lg_big;
        lg_big = (lga > lgb) ? lga : lgb;
        return blk_hit(a, b, lg_big);
    endfunction

endpackage

// File: rtl/msb_entry_table.sv
// Module: storage for outstanding coprocessor operations.
// One slot per operation holds a pending flag, source base, destination base
// and size exponent. Allocation and release come from the controller; an
// allocation and a release aimed at the same slot in one cycle resolve in
// favour of the allocation (the release then targets a free slot).
module msb_entry_table #(
    parameter int ADDR_W  = 16,
    parameter int LG_W    = 4,
    parameter int ENTRIES = 4,
    localparam int IDX_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic                             alloc_en,
    input  logic [IDX_W-1:0]                 alloc_idx,
    input  logic [ADDR_W-1:0]                alloc_src,
    input  logic [ADDR_W-1:0]                alloc_dst,
    input  logic [LG_W-1:0]                  alloc_lg,
    input  logic                             free_en,
    input  logic [IDX_W-1:0]                 free_idx,
    output logic [ENTRIES-1:0]               ent_valid,
    output logic [ENTRIES-1:0][ADDR_W-1:0]   ent_src,
    output logic [ENTRIES-1:0][ADDR_W-1:0]   ent_dst,
    output logic [ENTRIES-1:0][LG_W-1:0]     ent_lg
);

    for (genvar i = 0; i < ENTRIES; i++) begin : g_slot
        logic hit_alloc;
        logic hit_free;

        // Decode whether this slot is targeted by an allocation or a release.
        always_comb begin
            hit_alloc = alloc_en && (alloc_idx == IDX_W'(i));
            hit_free  = free_en  && (free_idx  == IDX_W'(i));
        end

        // Update the pending flag: allocation sets it, release clears it.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                ent_valid[i] <= 1'b0;
            end else if (hit_alloc) begin
                ent_valid[i] <= 1'b1;
            end else if (hit_free) begin
                ent_valid[i] <= 1'b0;
            end
        end

        // Capture the region description when the slot is allocated.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                ent_src[i] <= '0;
                ent_dst[i] <= '0;
                ent_lg[i]  <= '0;
            end else if (hit_alloc) begin
                ent_src[i] <= alloc_src;
                ent_dst[i] <= alloc_dst;
                ent_lg[i]  <= alloc_lg;
            end
        end
    end

endmodule

// File: rtl/msb_region_match.sv
// Module: parallel region comparators, one set per table slot.
// For each pending slot it reports whether the access address falls in the
// destination block, in either block, and whether the candidate source block
// overlaps the slot's destination block. Purely combinational.
module msb_region_match #(
    parameter int ADDR_W  = 16,
    parameter int LG_W    = 4,
    parameter int ENTRIES = 4
) (
    input  logic [ENTRIES-1:0]               ent_valid,
    input  logic [ENTRIES-1:0][ADDR_W-1:0]   ent_src,
    input  logic [ENTRIES-1:0][ADDR_W-1:0]   ent_dst,
    input  logic [ENTRIES-1:0][LG_W-1:0]     ent_lg,
    input  logic [ADDR_W-1:0]                acc_addr,
    input  logic [ADDR_W-1:0]                new_src,
    input  logic [LG_W-1:0]                  new_lg,
    output logic [ENTRIES-1:0]               rd_hit,
    output logic [ENTRIES-1:0]               wr_hit,
    output logic [ENTRIES-1:0]               src_clash
);
    import msb_pkg::*;

    for (genvar i = 0; i < ENTRIES; i++) begin : g_cmp
        logic in_dst;
        logic in_src;
        logic ovl;

        // Compare the access and the candidate source against this slot.
        always_comb begin
            in_dst = blk_hit(MSB_AW_MAX'(acc_addr), MSB_AW_MAX'(ent_dst[i]), 7'(ent_lg[i]));
            in_src = blk_hit(MSB_AW_MAX'(acc_addr), MSB_AW_MAX'(ent_src[i]), 7'(ent_lg[i]));
            ovl    = blk_overlap(MSB_AW_MAX'(new_src), 7'(new_lg),
                                 MSB_AW_MAX'(ent_dst[i]), 7'(ent_lg[i]));
        end

        // Qualify each comparison with the slot's pending flag.
        always_comb begin
            rd_hit[i]    = ent_valid[i] && in_dst;
            wr_hit[i]    = ent_valid[i] && (in_dst || in_src);
            src_clash[i] = ent_valid[i] && ovl;
        end
    end

endmodule

// File: rtl/msb_issue_ctl.sv
// Module: issue acceptance and slot choice.
// Picks the lowest free slot and accepts a new operation only when a slot is
// free and its source block avoids every pending destination. Decisions use
// the table state at the start of the cycle, so a slot being released in the
// same cycle still counts as pending.
module msb_issue_ctl #(
    parameter int ENTRIES = 4,
    localparam int IDX_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
    input  logic [ENTRIES-1:0] ent_valid,
    input  logic [ENTRIES-1:0] src_clash,
    input  logic               issue_valid,
    output logic               issue_ready,
    output logic [IDX_W-1:0]   issue_idx,
    output logic               alloc_en
);

    logic any_free;

    // Priority search for the lowest-numbered free slot.
    always_comb begin
        issue_idx = '0;
        any_free  = 1'b0;
        for (int i = ENTRIES - 1; i >= 0; i--) begin
            if (!ent_valid[i]) begin
                issue_idx = IDX_W'(i);
                any_free  = 1'b1;
            end
        end
    end

    // Accept when there is room and no read-after-write hazard on the source.
    always_comb begin
        issue_ready = any_free && !(|src_clash);
        alloc_en    = issue_valid && issue_ready;
    end

endmodule

// File: rtl/memreg_scoreboard.sv
// Module: memory region scoreboard (top).
// Records the source and destination blocks of outstanding memory-to-memory
// coprocessor operations and stalls conflicting processor loads and stores.
// Assumes the coprocessor reports each completion once, by entry index.
module memreg_scoreboard #(
    parameter int ADDR_W  = 16,
    parameter int LG_W    = 4,
    parameter int ENTRIES = 4,
    localparam int IDX_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              issue_valid,
    input  logic [ADDR_W-1:0] issue_src,
    input  logic [ADDR_W-1:0] issue_dst,
    input  logic [LG_W-1:0]   issue_lg,
    output logic              issue_ready,
    output logic [IDX_W-1:0]  issue_idx,
    input  logic              done_valid,
    input  logic [IDX_W-1:0]  done_idx,
    input  logic              acc_valid,
    input  logic              acc_write,
    input  logic [ADDR_W-1:0] acc_addr,
    output logic              acc_stall
);

    logic [ENTRIES-1:0]             ent_valid;
    logic [ENTRIES-1:0][ADDR_W-1:0] ent_src;
    logic [ENTRIES-1:0][ADDR_W-1:0] ent_dst;
    logic [ENTRIES-1:0][LG_W-1:0]   ent_lg;
    logic [ENTRIES-1:0]             rd_hit;
    logic [ENTRIES-1:0]             wr_hit;
    logic [ENTRIES-1:0]             src_clash;
    logic                           alloc_en;

    msb_entry_table #(
        .ADDR_W (ADDR_W),
        .LG_W   (LG_W),
        .ENTRIES(ENTRIES)
    ) u_table (
        .clk      (clk),
        .rst_n    (rst_n),
        .alloc_en (alloc_en),
        .alloc_idx(issue_idx),
        .alloc_src(issue_src),
        .alloc_dst(issue_dst),
        .alloc_lg (issue_lg),
        .free_en  (done_valid),
        .free_idx (done_idx),
        .ent_valid(ent_valid),
        .ent_src  (ent_src),
        .ent_dst  (ent_dst),
        .ent_lg   (ent_lg)
    );

    msb_region_match #(
        .ADDR_W (ADDR_W),
        .LG_W   (LG_W),
        .ENTRIES(ENTRIES)
    ) u_match (
        .ent_valid(ent_valid),
        .ent_src  (ent_src),
        .ent_dst  (ent_dst),
        .ent_lg   (ent_lg),
        .acc_addr (acc_addr),
        .new_src  (issue_src),
        .new_lg   (issue_lg),
        .rd_hit   (rd_hit),
        .wr_hit   (wr_hit),
        .src_clash(src_clash)
    );

    msb_issue_ctl #(
        .ENTRIES(ENTRIES)
    ) u_ctl (
        .ent_valid  (ent_valid),
        .src_clash  (src_clash),
        .issue_valid(issue_valid),
        .issue_ready(issue_ready),
        .issue_idx  (issue_idx),
        .alloc_en   (alloc_en)
    );

    // Stall a load on a pending destination, a store on any pending block.
    always_comb begin
        acc_stall = acc_valid && (acc_write ? (|wr_hit) : (|rd_hit));
    end

endmodule

// File: rtl/msb_checker.sv
// Module: temporal checks for the memory region scoreboard, bound to the top.
// Observes the ports plus the slot pending flags.
module msb_checker #(
    parameter int ENTRIES = 4,
    parameter int IDX_W   = 2
) (
    input logic               clk,
    input logic               rst_n,
    input logic               issue_valid,
    input logic               issue_ready,
    input logic [IDX_W-1:0]   issue_idx,
    input logic               done_valid,
    input logic [IDX_W-1:0]   done_idx,
    input logic               acc_valid,
    input logic               acc_stall,
    input logic [ENTRIES-1:0] ent_valid
);

    // R1: nothing pending means no access can stall.
    p_empty_no_stall_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (ent_valid == '0) |-> !acc_stall);

    // R6: the offered slot is a free one.
    p_idx_is_free_r6: assert property (@(posedge clk) disable iff (!rst_n)
        issue_ready |-> !ent_valid[issue_idx]);

    // R6: an accepted issue makes its slot pending on the next cycle.
    p_alloc_marks_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (issue_valid && issue_ready) |=> ent_valid[$past(issue_idx)]);

    // R7: a full table never accepts.
    p_no_overflow_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ($countones(ent_valid) == ENTRIES) |-> !issue_ready);

    // R9: completing a pending slot frees it on the next cycle.
    p_done_frees_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (done_valid && ent_valid[done_idx]) |=> !ent_valid[$past(done_idx)]);

    // R11: no access, no stall.
    p_idle_no_stall_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !acc_valid |-> !acc_stall);

endmodule

bind memreg_scoreboard msb_checker #(
    .ENTRIES(ENTRIES),
    .IDX_W  (IDX_W)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .issue_valid(issue_valid),
    .issue_ready(issue_ready),
    .issue_idx  (issue_idx),
    .done_valid (done_valid),
    .done_idx   (done_idx),
    .acc_valid  (acc_valid),
    .acc_stall  (acc_stall),
    .ent_valid  (ent_valid)
);

// File: tb/memreg_scoreboard_bench.sv
// Bench: small configuration (8-bit addresses, 4 slots), full address sweeps
// against a bench-side region model.
module memreg_scoreboard_bench;

    localparam int AW = 8;
    localparam int LW = 4;
    localparam int NE = 4;
    localparam int IW = 2;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          issue_valid;
    logic [AW-1:0] issue_src;
    logic [AW-1:0] issue_dst;
    logic [LW-1:0] issue_lg;
    logic          issue_ready;
    logic [IW-1:0] issue_idx;
    logic          done_valid;
    logic [IW-1:0] done_idx;
    logic          acc_valid;
    logic          acc_write;
    logic [AW-1:0] acc_addr;
    logic          acc_stall;

    always #10 clk = ~clk;

    memreg_scoreboard #(.ADDR_W(AW), .LG_W(LW), .ENTRIES(NE)) u_memreg_scoreboard (
        .clk(clk), .rst_n(rst_n),
        .issue_valid(issue_valid), .issue_src(issue_src), .issue_dst(issue_dst),
        .issue_lg(issue_lg), .issue_ready(issue_ready), .issue_idx(issue_idx),
        .done_valid(done_valid), .done_idx(done_idx),
        .acc_valid(acc_valid), .acc_write(acc_write), .acc_addr(acc_addr),
        .acc_stall(acc_stall)
    );

    int n_vec = 0;
    int n_bad = 0;

    bit          mv [NE];
    logic [AW-1:0] ms [NE];
    logic [AW-1:0] md [NE];
    logic [LW-1:0] ml [NE];

    function automatic bit inb(logic [AW-1:0] a, logic [AW-1:0] b, logic [LW-1:0] lg);
        logic [AW-1:0] d;
        d = (a ^ b) >> lg;
        return d == '0;
    endfunction

    function automatic bit exp_stall();
        bit s = 0;
        if (!acc_valid) return 0;
        for (int i = 0; i < NE; i++) begin
            if (mv[i] && inb(acc_addr, md[i], ml[i])) s = 1;
            if (mv[i] && acc_write && inb(acc_addr, ms[i], ml[i])) s = 1;
        end
        return s;
    endfunction

    function automatic bit exp_ready();
        int cnt = 0;
        bit clash = 0;
        for (int i = 0; i < NE; i++) begin
            logic [LW-1:0] big;
            big = (issue_lg > ml[i]) ? issue_lg : ml[i];
            if (mv[i]) cnt++;
            if (mv[i] && inb(issue_src, md[i], big)) clash = 1;
        end
        return (cnt < NE) && !clash;
    endfunction

    function automatic int exp_idx();
        for (int i = 0; i < NE; i++) if (!mv[i]) return i;
        return 0;
    endfunction

    task automatic chk(string req, string what, int act, int exp);
        n_vec++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic idle_inputs();
        issue_valid = 0; issue_src = '0; issue_dst = '0; issue_lg = '0;
        done_valid = 0; done_idx = '0;
        acc_valid = 0; acc_write = 0; acc_addr = '0;
    endtask

    // Called just after a falling edge with inputs set: check, clock, update model.
    task automatic tick(string req);
        bit er;
        int ei;
        #2;
        chk(req, "acc_stall", int'(acc_stall), int'(exp_stall()));
        er = exp_ready();
        ei = exp_idx();
        chk(req, "issue_ready", int'(issue_ready), int'(er));
        if (er) chk(req, "issue_idx", int'(issue_idx), ei);
        @(posedge clk);
        if (issue_valid && er) begin
            mv[ei] = 1; ms[ei] = issue_src; md[ei] = issue_dst; ml[ei] = issue_lg;
        end
        if (done_valid && !(issue_valid && er && ei == int'(done_idx))) mv[done_idx] = 0;
        @(negedge clk);
        idle_inputs();
    endtask

    task automatic issue(logic [AW-1:0] s, logic [AW-1:0] d, logic [LW-1:0] lg, string req);
        issue_valid = 1; issue_src = s; issue_dst = d; issue_lg = lg;
        tick(req);
    endtask

    // Every address as a load and as a store, one per cycle.
    task automatic sweep();
        for (int w = 0; w < 2; w++) begin
            for (int a = 0; a < (1 << AW); a++) begin
                acc_valid = 1; acc_write = w[0]; acc_addr = AW'(a);
                #2;
                chk(w ? "R4 R5" : "R2 R3 R5", "acc_stall sweep",
                    int'(acc_stall), int'(exp_stall()));
                @(negedge clk);
            end
        end
        idle_inputs();
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        for (int i = 0; i < NE; i++) begin mv[i] = 0; ms[i] = '0; md[i] = '0; ml[i] = '0; end
        idle_inputs();
        rst_n = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1;

        // R1: empty after reset
        acc_valid = 1; acc_write = 1; acc_addr = 8'h80;
        tick("R1");
        sweep();

        // R6: first allocations go to slots 0 and 1; R5 unaligned base
        issue(8'h40, 8'h80, 4'd4, "R6");
        sweep();
        issue(8'h10, 8'h23, 4'd2, "R6 R5");
        sweep();

        // R10: done on free slot 3, then pending state unchanged
        done_valid = 1; done_idx = 2'd3;
        acc_valid = 1; acc_addr = 8'h85;
        tick("R10");
        acc_valid = 1; acc_addr = 8'h85;
        tick("R10");
        acc_valid = 1; acc_write = 1; acc_addr = 8'h12;
        tick("R10");

        // R8: source overlapping a pending destination is held
        for (int k = 0; k < 3; k++) issue(8'h88, 8'hC0, 4'd2, "R8");
        issue(8'h00, 8'hC0, 4'd8, "R8 larger size");
        issue(8'h20, 8'hC0, 4'd0, "R8 single byte");
        // R9/R12: release slot 0 while held issue still offered
        issue_valid = 1; issue_src = 8'h88; issue_dst = 8'hC0; issue_lg = 4'd2;
        done_valid = 1; done_idx = 2'd0;
        acc_valid = 1; acc_addr = 8'h85;
        tick("R9 R12");
        acc_valid = 1; acc_addr = 8'h85;
        issue(8'h88, 8'hC0, 4'd2, "R9 R8");
        sweep();

        // R6/R7: fill and overflow
        issue(8'h50, 8'h60, 4'd4, "R6");
        issue(8'h70, 8'h71, 4'd0, "R6");
        issue(8'h00, 8'h01, 4'd0, "R7");
        issue(8'hF0, 8'hF8, 4'd3, "R7");
        sweep();

        // R12: full table, release slot 2 and issue in same cycle
        issue_valid = 1; issue_src = 8'hE0; issue_dst = 8'hE8; issue_lg = 4'd3;
        done_valid = 1; done_idx = 2'd2;
        tick("R12");
        issue(8'hE0, 8'hE8, 4'd3, "R12 reuse");

        // R11: no access, no stall even on a pending destination
        acc_valid = 0; acc_write = 1; acc_addr = 8'hC1;
        tick("R11");
        acc_valid = 0; acc_write = 0; acc_addr = 8'hE9;
        tick("R11");

        // R9: retire all, nothing stalls afterwards
        for (int i = 0; i < NE; i++) begin
            done_valid = 1; done_idx = IW'(i);
            tick("R9");
        end
        sweep();

        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule